// File: doc/BRIEF.md
# Nested Priority Interrupt Dispatcher

This block sits between the interrupt sources of a processor core and the sequencer that enters a service routine. It collects requests from four source groups: a set of internal exception lines, one nonmaskable line, a software trap port that carries an 8-bit type, and a maskable external request line that also carries an 8-bit type. In each decision cycle it picks at most one request and announces it with a one-cycle dispatch strobe and the chosen 8-bit type. The core then fetches the vector and saves its state; neither is done here.

Each request has a rank. The group decides first, with exceptions the most urgent, then the nonmaskable line, then software traps, then external requests. Within a group, the lower type number wins. The dispatcher remembers the rank of the routine now running and keeps a small stack of the routines it has interrupted. A new request may cut in only when its rank is strictly better than the running one and the stack still has room. An end-of-service pulse resumes the interrupted routine. A maskable-enable flag gates only the external line. Software sets and clears it with two command inputs, and every dispatch clears it.

Top module: `irq_nest_dispatch`

## Requirements
- R1: After reset `disp_vld` is 0, `if_flag` is 0 and `nest_lvl` is 0.
- R2: Rank is ordered by group first: exceptions, then nonmaskable, then software trap, then external. Within a group the lower type wins. `exc_req[0]`, `[1]`, `[2]` and `[3]` stand for types 0, 1, 3 and 4. The nonmaskable request dispatches as type 2.
- R3: `ext_req` is considered only while `if_flag` is 1. The nonmaskable request is never gated by the flag.
- R4: `sti` sets and `cli` clears `if_flag` from the next cycle on. When both are high, `cli` wins.
- R5: Every dispatch clears `if_flag`, unless a `sti` in the same cycle sets it again.
- R6: While a routine is active, a request preempts it only if its rank is strictly better, including a lower type in the same group. Each dispatch raises `nest_lvl` by one.
- R7: A request that is not better stays pending, without dispatch, until end-of-service makes it the best. An `eoi` pulse restores the preempted routine as active and lowers `nest_lvl` by one.
- R8: At most four preempted routines are held, so `nest_lvl` never exceeds 5. At that level a better request waits until an `eoi` frees a slot.
- R9: In a cycle with `eoi` high no dispatch happens. An `eoi` while idle has no effect.
- R10: A software trap pulse latches `swi_type`. A second pulse while one trap is still pending is dropped.
- R11: A request pulse captured at clock edge k gives `disp_vld` high for exactly the one cycle after edge k+1, when that request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 4 | Exception pulses, bits map to types 0,1,3,4 |
| nmi_req | input | 1 | Nonmaskable request pulse |
| swi_req | input | 1 | Software trap pulse |
| swi_type | input | 8 | Type of the software trap |
| ext_req | input | 1 | Maskable external request level |
| ext_type | input | 8 | Type of the external request |
| sti | input | 1 | Set maskable-enable flag |
| cli | input | 1 | Clear maskable-enable flag |
| eoi | input | 1 | End of the active service routine |
| disp_vld | output | 1 | Dispatch strobe |
| disp_type | output | 8 | Type of the dispatched request |
| if_flag | output | 1 | Maskable-enable flag |
| nest_lvl | output | 3 | Active routine plus held preemptions |

## Verification
The bench raises an exception, the nonmaskable line and a software trap in the same cycle. The dispatch order that results separates group ranking from arrival order. Preemption is tried both across groups and inside the external and software groups with rising and falling types. This shows that the type is compared as well as the group, and that a worse or equal rank only waits. A chain that fills the four stack slots, an `eoi` held high over a pending trap, and a second trap pulse into an occupied slot separate the three ways a request can be held back: no stack room, end-of-service in progress, or a dropped request.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int TYPE_W = 8;
    localparam int GRP_W  = 2;
    localparam int RANK_W = GRP_W + TYPE_W;

    typedef enum logic [GRP_W-1:0] {
        GRP_EXC = 2'd0,
        GRP_NMI = 2'd1,
        GRP_SWI = 2'd2,
        GRP_EXT = 2'd3
    } grp_e;

    localparam logic [TYPE_W-1:0] NMI_TYPE = 8'd2;

    // exception lane index to type number, skipping the nonmaskable type
    function automatic logic [TYPE_W-1:0] exc_type(input int idx);
        if (idx < int'(NMI_TYPE)) return TYPE_W'(idx);
        return TYPE_W'(idx + 1);
    endfunction

    function automatic logic [RANK_W-1:0] mk_rank(input grp_e g, input logic [TYPE_W-1:0] t);
        return {g, t};
    endfunction
endpackage

// File: rtl/irq_nest_pend.sv
module irq_nest_pend
    import irq_nest_pkg::*;
#(
    parameter int NEXC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEXC-1:0]   exc_set,
    input  logic              nmi_set,
    input  logic              swi_set,
    input  logic [TYPE_W-1:0] swi_type_in,
    input  logic [NEXC-1:0]   exc_clr,
    input  logic              nmi_clr,
    input  logic              swi_clr,
    output logic [NEXC-1:0]   exc_pend,
    output logic              nmi_pend,
    output logic              swi_pend,
    output logic [TYPE_W-1:0] swi_type_pend
);
    typedef struct packed {
        logic [NEXC-1:0]   exc;
        logic              nmi;
        logic              swi;
        logic [TYPE_W-1:0] swi_t;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.exc = exc_set | (st_q.exc & ~exc_clr);
        st_d.nmi = nmi_set | (st_q.nmi & ~nmi_clr);
        if (swi_clr) st_d.swi = 1'b0;
        if (swi_set && !st_d.swi) begin
            st_d.swi   = 1'b1;
            st_d.swi_t = swi_type_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exc_pend      = st_q.exc;
    assign nmi_pend      = st_q.nmi;
    assign swi_pend      = st_q.swi;
    assign swi_type_pend = st_q.swi_t;
endmodule

// File: rtl/irq_nest_pick.sv
module irq_nest_pick
    import irq_nest_pkg::*;
#(
    parameter int NEXC = 4
) (
    input  logic [NEXC-1:0]   exc_pend,
    input  logic              nmi_pend,
    input  logic              swi_pend,
    input  logic [TYPE_W-1:0] swi_type_pend,
    input  logic              ext_req,
    input  logic [TYPE_W-1:0] ext_type,
    input  logic              ie,
    output logic              cand_vld,
    output logic [RANK_W-1:0] cand_rank,
    output grp_e              cand_grp,
    output logic [NEXC-1:0]   cand_exc
);
    logic              exc_any;
    logic [TYPE_W-1:0] exc_best;
    logic [NEXC-1:0]   exc_hot;

    // lowest lane holds the lowest type
    always_comb begin
        exc_any  = 1'b0;
        exc_best = '0;
        exc_hot  = '0;
        for (int i = NEXC - 1; i >= 0; i--) begin
            if (exc_pend[i]) begin
                exc_any  = 1'b1;
                exc_best = exc_type(i);
                exc_hot  = '0;
                exc_hot[i] = 1'b1;
            end
        end
    end

    always_comb begin
        cand_vld  = 1'b1;
        cand_grp  = GRP_EXC;
        cand_rank = '0;
        cand_exc  = '0;
        if (exc_any) begin
            cand_grp  = GRP_EXC;
            cand_rank = mk_rank(GRP_EXC, exc_best);
            cand_exc  = exc_hot;
        end else if (nmi_pend) begin
            cand_grp  = GRP_NMI;
            cand_rank = mk_rank(GRP_NMI, NMI_TYPE);
        end else if (swi_pend) begin
            cand_grp  = GRP_SWI;
            cand_rank = mk_rank(GRP_SWI, swi_type_pend);
        end else if (ext_req && ie) begin
            cand_grp  = GRP_EXT;
            cand_rank = mk_rank(GRP_EXT, ext_type);
        end else begin
            cand_vld  = 1'b0;
        end
    end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 10,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     top,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CNT_W-1:0]        cnt;
    } stk_t;

    stk_t st_d, st_q;

    assign full = (st_q.cnt == CNT_W'(DEPTH));
    assign cnt  = st_q.cnt;

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.cnt == CNT_W'(i + 1)) top = st_q.mem[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.cnt == CNT_W'(i)) st_d.mem[i] = din;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_nest_dispatch.sv
module irq_nest_dispatch
    import irq_nest_pkg::*;
#(
    parameter int NEXC  = 4,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEXC-1:0]   exc_req,
    input  logic              nmi_req,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              ext_req,
    input  logic [TYPE_W-1:0] ext_type,
    input  logic              sti,
    input  logic              cli,
    input  logic              eoi,
    output logic              disp_vld,
    output logic [TYPE_W-1:0] disp_type,
    output logic              if_flag,
    output logic [LVL_W-1:0]  nest_lvl
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              ie;
        logic              act_vld;
        logic [RANK_W-1:0] act_rank;
        logic              disp_vld;
        logic [TYPE_W-1:0] disp_type;
    } core_t;

    core_t cr_d, cr_q;

    logic [NEXC-1:0]   exc_pend, exc_clr, cand_exc;
    logic              nmi_pend, swi_pend, nmi_clr, swi_clr;
    logic [TYPE_W-1:0] swi_type_pend;
    logic              cand_vld;
    logic [RANK_W-1:0] cand_rank;
    grp_e              cand_grp;
    logic              stk_push, stk_pop, stk_full;
    logic [RANK_W-1:0] stk_top;
    logic [CNT_W-1:0]  stk_cnt;
    logic              take;

    irq_nest_pend #(.NEXC(NEXC)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .exc_set(exc_req), .nmi_set(nmi_req),
        .swi_set(swi_req), .swi_type_in(swi_type),
        .exc_clr(exc_clr), .nmi_clr(nmi_clr), .swi_clr(swi_clr),
        .exc_pend(exc_pend), .nmi_pend(nmi_pend),
        .swi_pend(swi_pend), .swi_type_pend(swi_type_pend)
    );

    irq_nest_pick #(.NEXC(NEXC)) u_pick (
        .exc_pend(exc_pend), .nmi_pend(nmi_pend),
        .swi_pend(swi_pend), .swi_type_pend(swi_type_pend),
        .ext_req(ext_req), .ext_type(ext_type), .ie(cr_q.ie),
        .cand_vld(cand_vld), .cand_rank(cand_rank),
        .cand_grp(cand_grp), .cand_exc(cand_exc)
    );

    irq_nest_stack #(.DEPTH(DEPTH), .W(RANK_W)) u_stk (
        .clk(clk), .rst_n(rst_n),
        .push(stk_push), .pop(stk_pop), .din(cr_q.act_rank),
        .top(stk_top), .cnt(stk_cnt), .full(stk_full)
    );

    // a dispatch happens only outside end-of-service and with strict rank gain
    assign take = !eoi && cand_vld &&
                  (!cr_q.act_vld || (cand_rank < cr_q.act_rank && !stk_full));

    always_comb begin
        cr_d          = cr_q;
        cr_d.disp_vld = 1'b0;
        exc_clr       = '0;
        nmi_clr       = 1'b0;
        swi_clr       = 1'b0;
        stk_push      = 1'b0;
        stk_pop       = 1'b0;
        if (eoi) begin
            if (cr_q.act_vld) begin
                if (stk_cnt != '0) begin
                    stk_pop       = 1'b1;
                    cr_d.act_rank = stk_top;
                end else begin
                    cr_d.act_vld  = 1'b0;
                end
            end
        end else if (take) begin
            cr_d.disp_vld  = 1'b1;
            cr_d.disp_type = cand_rank[TYPE_W-1:0];
            cr_d.act_vld   = 1'b1;
            cr_d.act_rank  = cand_rank;
            cr_d.ie        = 1'b0;
            stk_push       = cr_q.act_vld;
            case (cand_grp)
                GRP_EXC: exc_clr = cand_exc;
                GRP_NMI: nmi_clr = 1'b1;
                GRP_SWI: swi_clr = 1'b1;
                default: ;
            endcase
        end
        if (cli)      cr_d.ie = 1'b0;
        else if (sti) cr_d.ie = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign disp_vld  = cr_q.disp_vld;
    assign disp_type = cr_q.disp_type;
    assign if_flag   = cr_q.ie;
    assign nest_lvl  = LVL_W'(cr_q.act_vld) + LVL_W'(stk_cnt);
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sti,
    input logic             cli,
    input logic             eoi,
    input logic             disp_vld,
    input logic             if_flag,
    input logic [LVL_W-1:0] nest_lvl
);
    // R9
    eoi_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |-> !$past(eoi));
    // R5
    disp_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld && !$past(sti)) |-> !if_flag);
    // R4
    cli_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cli |=> !if_flag);
    // R6
    disp_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |-> (nest_lvl == LVL_W'($past(nest_lvl) + 1'b1)));
    // R7
    eoi_unnests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && nest_lvl != '0) |=> (nest_lvl == LVL_W'($past(nest_lvl) - 1'b1)));
    // R8
    depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nest_lvl <= LVL_W'(DEPTH + 1));
endmodule

bind irq_nest_dispatch irq_nest_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sti(sti), .cli(cli), .eoi(eoi),
    .disp_vld(disp_vld), .if_flag(if_flag), .nest_lvl(nest_lvl)
);

// File: tb/sim_irq_nest_dispatch.sv
`timescale 1ns/1ps
module sim_irq_nest_dispatch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] exc_req = '0;
    logic       nmi_req = 1'b0, swi_req = 1'b0, ext_req = 1'b0;
    logic [7:0] swi_type = '0, ext_type = '0;
    logic       sti = 1'b0, cli = 1'b0, eoi = 1'b0;
    logic       disp_vld, if_flag;
    logic [7:0] disp_type;
    logic [2:0] nest_lvl;

    int total = 0;
    int bad = 0;
    logic [7:0] expq[$];
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_nest_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .nmi_req(nmi_req),
        .swi_req(swi_req), .swi_type(swi_type), .ext_req(ext_req),
        .ext_type(ext_type), .sti(sti), .cli(cli), .eoi(eoi),
        .disp_vld(disp_vld), .disp_type(disp_type),
        .if_flag(if_flag), .nest_lvl(nest_lvl)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: every dispatch must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && disp_vld) begin
            total++;
            if (expq.size() == 0) begin
                bad++;
                $display("FAIL R2/R6 unexpected dispatch actual=%0d expected=none", disp_type);
            end else begin
                automatic logic [7:0] e = expq.pop_front();
                if (disp_type != e) begin
                    bad++;
                    $display("FAIL R2/R6 dispatch order actual=%0d expected=%0d", disp_type, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic p_exc(input int lane);
        @(negedge clk); exc_req[lane] = 1'b1;
        @(negedge clk); exc_req = '0;
    endtask
    task automatic p_nmi;
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
    endtask
    task automatic p_swi(input logic [7:0] t);
        @(negedge clk); swi_req = 1'b1; swi_type = t;
        @(negedge clk); swi_req = 1'b0;
    endtask
    task automatic p_sti;
        @(negedge clk); sti = 1'b1;
        @(negedge clk); sti = 1'b0;
    endtask
    task automatic p_eoi;
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 disp_vld", disp_vld, 0);
        check("R1 if_flag", if_flag, 0);
        check("R1 nest_lvl", nest_lvl, 0);

        // R3 external held while flag is clear
        ext_req = 1'b1; ext_type = 8'h40;
        idle(5);
        check("R3 masked ext level", nest_lvl, 0);
        expq.push_back(8'h40);
        p_sti;
        idle(2);
        check("R3 ext after sti", nest_lvl, 1);
        check("R5 flag cleared by dispatch", if_flag, 0);
        ext_req = 1'b0;
        // R6 software trap preempts external
        expq.push_back(8'h80);
        p_swi(8'h80);
        idle(2);
        check("R6 cross-group preempt", nest_lvl, 2);
        p_eoi;
        check("R7 eoi pops", nest_lvl, 1);
        p_eoi;
        idle(1);
        check("R7 back to idle", nest_lvl, 0);

        // R2 three groups raised together
        expq.push_back(8'd4);
        expq.push_back(8'd2);
        expq.push_back(8'h21);
        @(negedge clk); exc_req[3] = 1'b1; nmi_req = 1'b1; swi_req = 1'b1; swi_type = 8'h21;
        @(negedge clk); exc_req = '0; nmi_req = 1'b0; swi_req = 1'b0;
        idle(4);
        check("R2 only best dispatched", nest_lvl, 1);
        check("R2 others wait", int'(expq.size()), 2);
        p_eoi; idle(2);
        check("R2 nmi after exception", int'(expq.size()), 1);
        p_eoi; idle(2);
        check("R2 swi last", int'(expq.size()), 0);
        p_eoi; idle(2);
        check("R7 idle again", nest_lvl, 0);

        // R6 same-group type compare for external
        p_sti;
        expq.push_back(8'h50);
        ext_type = 8'h50; ext_req = 1'b1;
        idle(2); ext_req = 1'b0;
        p_sti;
        expq.push_back(8'h30);
        ext_type = 8'h30; ext_req = 1'b1;
        idle(2); ext_req = 1'b0;
        check("R6 lower type preempts", nest_lvl, 2);
        p_sti;
        ext_type = 8'h60; ext_req = 1'b1;
        idle(4);
        check("R7 higher type waits", nest_lvl, 2);
        check("R4 sti sets flag", if_flag, 1);
        p_eoi; idle(2);
        check("R7 restored 0x50 still blocks", nest_lvl, 1);
        expq.push_back(8'h60);
        p_eoi; idle(2);
        check("R7 waiting ext served", nest_lvl, 1);
        check("R5 flag cleared", if_flag, 0);
        ext_req = 1'b0;
        p_eoi; idle(2);

        // R4 command priority
        @(negedge clk); sti = 1'b1; cli = 1'b1;
        @(negedge clk); sti = 1'b0; cli = 1'b0;
        check("R4 cli beats sti", if_flag, 0);
        p_sti;
        check("R4 sti", if_flag, 1);
        @(negedge clk); cli = 1'b1;
        @(negedge clk); cli = 1'b0;
        check("R4 cli", if_flag, 0);

        // R11 exact timing, R8 full stack
        expq.push_back(8'hF0);
        p_swi(8'hF0);
        check("R11 not yet", disp_vld, 0);
        @(negedge clk);
        check("R11 strobe cycle", disp_vld, 1);
        @(negedge clk);
        check("R11 strobe one cycle", disp_vld, 0);
        expq.push_back(8'h80); p_swi(8'h80); idle(2);
        expq.push_back(8'd2);  p_nmi;        idle(2);
        check("R3 nmi ignores flag", nest_lvl, 3);
        expq.push_back(8'd4);  p_exc(3);     idle(2);
        expq.push_back(8'd1);  p_exc(1);     idle(2);
        check("R8 five levels", nest_lvl, 5);
        p_exc(0); idle(4);
        check("R8 full blocks", nest_lvl, 5);
        check("R8 type0 waiting", int'(expq.size()), 0);
        expq.push_back(8'd0);
        p_eoi; idle(2);
        check("R8 slot freed then preempt", nest_lvl, 5);
        for (int i = 0; i < 5; i++) begin
            p_eoi; idle(1);
        end
        check("R7 unwound", nest_lvl, 0);

        // R9 eoi blocks dispatch and is harmless while idle
        @(negedge clk); eoi = 1'b1;
        p_swi(8'h33);
        idle(3);
        check("R9 no dispatch under eoi", nest_lvl, 0);
        expq.push_back(8'h33);
        eoi = 1'b0;
        idle(2);
        check("R9 dispatch after eoi", nest_lvl, 1);
        p_eoi; idle(1);

        // R10 occupied software slot drops second pulse
        expq.push_back(8'd1);
        p_exc(1); idle(1);
        p_swi(8'h30);
        p_swi(8'h31);
        idle(2);
        check("R10 trap waits", nest_lvl, 1);
        expq.push_back(8'h30);
        p_eoi; idle(2);
        check("R10 first trap served", nest_lvl, 1);
        p_eoi; idle(4);
        check("R10 second trap dropped", nest_lvl, 0);
        check("R10 scoreboard empty", int'(expq.size()), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule